// File: doc/BRIEF.md
# Synchronous FIFO with Selectable Fall-Through Read Timing

This block is a single-clock FIFO that stores 36-bit words. Its depth is a parameter. The read-side timing is chosen once, when the block comes out of reset, and there are two choices.

- **Standard timing:** a word reaches the read data output only after a read request has been accepted.
- **Fall-through timing:** the word at the head of the queue is placed on the output by itself. The consumer sees it there and takes it with a read.

In both timings the block drives two flags:

- `out_rdy_o`: a readable word is available.
- `in_rdy_o`: there is room for a write.

In fall-through timing, one storage slot is the output register itself. The total capacity is therefore the memory depth plus one. The flags are the only handshake: a request made while its flag is low is dropped.

A typical use is a datapath stage where the consumer wants the head word on the output without an extra request cycle. For that, the system ties the select input low during reset. Designs that expect classic read-then-data timing tie it high.

Top module: `sync_fall_thru_fifo`

## Requirements
- R1: The timing select `fall_thru_ni` is sampled on the first rising clock edge after `rst_ni` goes high. A low level there selects fall-through timing and a high level selects standard timing.
- R2: After that first edge the timing stays fixed until the next reset. Later changes of `fall_thru_ni` have no effect on behaviour.
- R3: In fall-through timing, a word written into an empty FIFO appears on `rd_data_o`, with `out_rdy_o` high, after the second rising edge counted from the write edge. No read request is needed.
- R4: In fall-through timing, the word on `rd_data_o` and `out_rdy_o` hold while `rd_en_i` is low. An edge with `rd_en_i` and `out_rdy_o` both high consumes the word and advances the next stored word to the output.
- R5: In fall-through timing, `out_rdy_o` is high exactly when a valid word is on the output. `in_rdy_o` drops only when the memory and the output register are all occupied, which is `DEPTH`+1 words.
- R6: A read with `out_rdy_o` low, or a write with `in_rdy_o` low, is ignored. Stored data, order and occupancy are unchanged.
- R7: In standard timing:
  - `out_rdy_o` is high when the FIFO is not empty, and `in_rdy_o` is high when fewer than `DEPTH` words are stored.
  - The word for an accepted read is on `rd_data_o` after that same edge and holds until the next accepted read.
  - A write never reaches the output by itself.
- R8: While `rst_ni` is low the FIFO is emptied, `out_rdy_o` is low, `in_rdy_o` is high and `rd_data_o` is zero.
- R9: Words leave in the order in which they were accepted, in both timings. This includes cycles that accept a read and a write together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| fall_thru_ni | input | 1 | Timing select, sampled once after reset; low = fall-through |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 36 | Write data |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | 36 | Read data |
| out_rdy_o | output | 1 | Readable word available (not empty in standard timing) |
| in_rdy_o | output | 1 | Space available for a write |

## Verification
Several properties are checked on every cycle by the assertions:
- Memory never overflows or underflows.
- Occupancy stays within bounds.
- The latched timing never changes after its sampling edge.
- A fall-through output word holds while unread.
- A stored word reaches an idle output register within one edge.
- In standard timing, an accepted read delivers the head word on the following cycle.

Some behaviours only the bench's scenarios can show:
- The exact capacities of `DEPTH`+1 and `DEPTH` words.
- That a select change after reset is ignored.
- The absence of fall-through in standard timing.
- End-to-end ordering under mixed simultaneous reads and writes, which a scoreboard compares word by word.

// File: rtl/fall_thru_fifo_pkg.sv
package fall_thru_fifo_pkg;
  localparam int unsigned DATA_W = 36;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic {
    TM_STANDARD = 1'b0,
    TM_FALL     = 1'b1
  } tmode_e;
endpackage

// File: rtl/fifo_mode_latch.sv
module fifo_mode_latch
  import fall_thru_fifo_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sel_ni,
  output tmode_e mode_o
);
  logic   done_q;
  tmode_e mode_q;

  // sample once on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      mode_q <= TM_STANDARD;
    end else if (!done_q) begin
      done_q <= 1'b1;
      mode_q <= sel_ni ? TM_STANDARD : TM_FALL;
    end
  end

  assign mode_o = mode_q;

  p_mode_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && $past(done_q)) |-> $stable(mode_q))
    else $error("timing mode changed after latch");
endmodule

// File: rtl/fifo_store.sv
module fifo_store
  import fall_thru_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  word_t wdata_i,
  input  logic  pop_i,
  output word_t head_o,
  output logic  empty_o,
  output logic  full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  word_t          mem_q [DEPTH];
  logic  [AW-1:0] wptr_q, rptr_q;
  logic  [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= bump(wptr_q);
      if (pop_i)  rptr_q <= bump(rptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_o  = mem_q[rptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i) else $error("push into full memory");
  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i) else $error("pop from empty memory");
  p_count_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)) else $error("occupancy out of range");
endmodule

// File: rtl/fifo_out_stage.sv
module fifo_out_stage
  import fall_thru_fifo_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  tmode_e mode_i,
  input  logic   store_empty_i,
  input  word_t  head_i,
  input  logic   rd_en_i,
  output logic   pop_o,
  output word_t  rd_data_o,
  output logic   out_rdy_o
);
  word_t data_q;
  logic  valid_q;
  logic  pop;

  always_comb begin
    if (mode_i == TM_FALL) begin
      out_rdy_o = valid_q;
      pop       = !store_empty_i && (!valid_q || rd_en_i);
    end else begin
      out_rdy_o = !store_empty_i;
      pop       = rd_en_i && !store_empty_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (pop) data_q <= head_i;
      if (mode_i != TM_FALL) valid_q <= 1'b0;
      else if (pop)          valid_q <= 1'b1;
      else if (rd_en_i)      valid_q <= 1'b0;
    end
  end

  assign pop_o     = pop;
  assign rd_data_o = data_q;

  p_fall_through_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TM_FALL && !valid_q && !store_empty_i) |=> out_rdy_o)
    else $error("head word did not fall through");
  p_hold_unread_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TM_FALL && out_rdy_o && !rd_en_i) |=> (out_rdy_o && $stable(rd_data_o)))
    else $error("unread output word changed");
  p_std_read_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TM_STANDARD && pop_o) |=> (rd_data_o == $past(head_i)))
    else $error("standard read returned wrong word");
endmodule

// File: rtl/sync_fall_thru_fifo.sv
module sync_fall_thru_fifo
  import fall_thru_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fall_thru_ni,
  input  logic        wr_en_i,
  input  logic [35:0] wr_data_i,
  input  logic        rd_en_i,
  output logic [35:0] rd_data_o,
  output logic        out_rdy_o,
  output logic        in_rdy_o
);
  tmode_e mode;
  word_t  head;
  logic   st_empty, st_full, push, pop;

  fifo_mode_latch i_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_ni (fall_thru_ni),
    .mode_o (mode)
  );

  assign in_rdy_o = !st_full;
  assign push     = wr_en_i && in_rdy_o;

  fifo_store #(.DEPTH(DEPTH)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (wr_data_i),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (st_empty),
    .full_o  (st_full)
  );

  fifo_out_stage i_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode),
    .store_empty_i (st_empty),
    .head_i        (head),
    .rd_en_i       (rd_en_i),
    .pop_o         (pop),
    .rd_data_o     (rd_data_o),
    .out_rdy_o     (out_rdy_o)
  );

  p_reset_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!out_rdy_o && in_rdy_o))
    else $error("flags wrong after reset");
endmodule

// File: tb/test_sync_fall_thru_fifo.sv
`timescale 1ns/1ps
module test_sync_fall_thru_fifo;
  localparam int unsigned DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fall_thru_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [35:0] rd_data;
  logic        out_rdy, in_rdy;

  int unsigned n_chk = 0, n_fail = 0;
  logic [35:0] exp_q[$];
  bit          exp_fall = 1'b0;
  bit          pend = 1'b0;
  bit          done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  sync_fall_thru_fifo #(.DEPTH(DEPTH)) i_sync_fall_thru_fifo (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .fall_thru_ni (fall_thru_ni),
    .wr_en_i      (wr_en),
    .wr_data_i    (wr_data),
    .rd_en_i      (rd_en),
    .rd_data_o    (rd_data),
    .out_rdy_o    (out_rdy),
    .in_rdy_o     (in_rdy)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: set inputs after the edge, record accepted writes mid-cycle
  task automatic cyc(input bit we, input logic [35:0] d, input bit re);
    @(posedge clk); #1;
    wr_en = we; wr_data = d; rd_en = re;
    @(negedge clk);
    if (we && in_rdy) exp_q.push_back(d);
  endtask

  // monitor: compares words leaving the FIFO against the scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (exp_fall) begin
        if (rd_en && out_rdy) begin
          if (exp_q.size() == 0) check("R6 read with empty scoreboard", 36'h1, 36'h0);
          else check("R9 fall-through order", rd_data, exp_q.pop_front());
        end
      end else begin
        if (pend) begin
          if (exp_q.size() == 0) check("R6 read with empty scoreboard", 36'h1, 36'h0);
          else check("R9 standard order", rd_data, exp_q.pop_front());
        end
        pend = rd_en && out_rdy;
      end
    end
  end

  task automatic do_reset(input bit sel);
    @(posedge clk); #1;
    rst_ni = 1'b0; wr_en = 0; rd_en = 0;
    fall_thru_ni = sel;
    exp_q.delete(); pend = 1'b0;
    exp_fall = !sel;
    @(negedge clk);
    check("R8 out_rdy in reset", {35'b0, out_rdy}, 36'h0);
    check("R8 in_rdy in reset", {35'b0, in_rdy}, 36'h1);
    check("R8 rd_data in reset", rd_data, 36'h0);
    rst_ni = 1'b1;
  endtask

  task automatic drain();
    for (int i = 0; i < 3 * DEPTH; i++) cyc(0, '0, 1);
    cyc(0, '0, 0);
    cyc(0, '0, 0);
    check("R9 scoreboard empty after drain", 36'(exp_q.size()), 36'h0);
    check("R5 out_rdy low after drain", {35'b0, out_rdy}, 36'h0);
  endtask

  task automatic stream(input int n, input logic [35:0] base);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[3], base + 36'(i), lfsr[1] | lfsr[5]);
    end
  endtask

  initial begin : main
    int acc;
    // ---------------- fall-through timing (R1 low select) ----------------
    do_reset(1'b0);
    cyc(0, '0, 0);                       // latch edge
    fall_thru_ni = 1'b1;                 // R2: later change must be ignored
    cyc(1, 36'h0_1234_5678, 0);
    cyc(0, '0, 0);                       // write edge passed
    check("R3 not yet visible after write edge", {35'b0, out_rdy}, 36'h0);
    cyc(0, '0, 0);                       // second edge
    check("R3 out_rdy without read", {35'b0, out_rdy}, 36'h1);
    check("R3 R1 R2 word fell through", rd_data, 36'h0_1234_5678);
    cyc(1, 36'h9_AAAA_0001, 0);
    cyc(0, '0, 0); cyc(0, '0, 0); cyc(0, '0, 0);
    check("R4 output held while unread", rd_data, 36'h0_1234_5678);
    cyc(0, '0, 1);                       // consume head
    cyc(0, '0, 0);
    check("R4 next word advanced after read", rd_data, 36'h9_AAAA_0001);
    drain();
    // read while empty is ignored
    cyc(0, '0, 1); cyc(0, '0, 1);
    check("R6 empty read keeps out_rdy low", {35'b0, out_rdy}, 36'h0);
    // fill: capacity DEPTH+1
    acc = 0;
    for (int i = 0; i < DEPTH + 4; i++) begin
      cyc(1, 36'h5_0000_0000 + 36'(i), 0);
      if (in_rdy || (exp_q.size() > 0 && exp_q[$] == 36'h5_0000_0000 + 36'(i))) ;
    end
    acc = exp_q.size();
    check("R5 fall-through capacity DEPTH+1", 36'(acc), 36'(DEPTH + 1));
    check("R5 in_rdy low when full", {35'b0, in_rdy}, 36'h0);
    check("R5 out_rdy high when full", {35'b0, out_rdy}, 36'h1);
    drain();                             // R6: rejected writes never appear
    stream(400, 36'h7_0000_0000);
    drain();

    // ---------------- standard timing (R1 high select) ----------------
    do_reset(1'b1);
    cyc(0, '0, 0);                       // latch edge
    fall_thru_ni = 1'b0;                 // R2: later change must be ignored
    cyc(1, 36'h3_CAFE_0001, 0);
    cyc(0, '0, 0); cyc(0, '0, 0);
    check("R7 not empty flag", {35'b0, out_rdy}, 36'h1);
    check("R7 R2 no fall-through in standard", rd_data, 36'h0);
    cyc(0, '0, 1);                       // accepted read
    cyc(0, '0, 0);
    check("R7 data one clock after read", rd_data, 36'h3_CAFE_0001);
    check("R7 empty after last read", {35'b0, out_rdy}, 36'h0);
    cyc(0, '0, 0);
    check("R7 data held after read", rd_data, 36'h3_CAFE_0001);
    for (int i = 0; i < DEPTH + 4; i++) cyc(1, 36'h6_0000_0000 + 36'(i), 0);
    check("R7 standard capacity DEPTH", 36'(exp_q.size()), 36'(DEPTH));
    check("R7 in_rdy low when full", {35'b0, in_rdy}, 36'h0);
    drain();
    stream(400, 36'h8_0000_0000);
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule